// File: doc/BRIEF.md
# PATA PIO Register Transfer Engine

This block is the host end of a parallel ATA channel for single-word programmed I/O. Software sets up a 16-bit register file over a simple write-strobe bus with combinational read-back: a device address, a word to send, and the clock counts for each phase. It then sets a start bit. The engine runs one bus cycle in three phases. An address-setup phase drives chip selects and the register address. A strobe phase pulls the read or write strobe low. An end-of-cycle phase releases the strobe while the address stays valid. For a read, the word on the device data bus is captured into a receive register. At the end of the cycle a completion flag is raised, and it can be routed to an interrupt output.

The data port (device address 0) has its own strobe and end-of-cycle counts. All other addresses use a separate pair of counts. This lets slow register accesses and faster data-port accesses share one engine. When the device-ready handshake is enabled, a device that pulls its ready line low stretches the strobe phase. Software can abort a cycle in flight, and the abort raises its own flag.

Register word indices: 0 control, 1 device address, 2 transmit word, 3 receive word, 4 interrupt mask, 5 interrupt status, 6 transfer length (read/write storage, no effect on a single-word access), 7 register-access timing, 8 data-port timing, 9 data-port strobe width.

Top module: `ata_pio_engine`

## Requirements
- R1: After synchronous reset every register reads 0, `ata_cs_n` is 2'b11, `ata_da` is 0, both strobes are high, `ata_dd_oe` is 0 and `irq` is 0.
- R2: During an access, device-address bit 3 = 0 drives `ata_cs_n` = 2'b10, and bit 3 = 1 drives 2'b01. `ata_da` carries address bits [2:0]. Both hold from the first setup clock to the last end-of-cycle clock. A strobe is never low while `ata_cs_n` is 2'b11.
- R3: Control bit 1 = 1 selects a write. `ata_diow_n` is low only in the strobe phase. `ata_dd_oe` is high through setup and strobe and for the first max(t4,1) end-of-cycle clocks, with the transmit word on `ata_dd_out`. The two strobes are never low together.
- R4: Control bit 1 = 0 selects a read. `ata_dior_n` is low only in the strobe phase. The value of `ata_dd_in` at the last strobe clock is stored in the receive register (index 3).
- R5: Setup lasts max(t1,1) clocks, with t1 = data-port timing [3:0]. At device address 0, strobe lasts max(index 9 [7:0],1) and end lasts max(data-port timing [11:4],1). At any other address, strobe lasts max(index 7 [15:8],1) and end lasts max(index 7 [7:0],1). t4 = data-port timing [15:12].
- R6: With control bit 2 set at start, each clock that `ata_iordy` is sampled low in the strobe phase holds the strobe low and adds one clock. With bit 2 clear, `ata_iordy` has no effect.
- R7: Status bit 0 is set on the clock edge where a cycle ends. Writing 1 to it at index 5 clears it, and writing 0 leaves it unchanged.
- R8: `irq` is high exactly when status AND mask (index 4, bit 0 done, bit 1 abort) is nonzero.
- R9: Control bit 0 (start) launches exactly one access and reads back as 0. A start written while an access is running is ignored.
- R10: A start written with control bit 3 (route through DMA) set is ignored: no bus cycle and no status change.
- R11: Control bit 4 written during an access ends it at that clock edge (the bus is idle from the next clock) and sets status bit 1, not bit 0. Written while idle, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ata_cs_n | output | 2 | Device chip selects, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data to device |
| ata_dd_oe | output | 1 | Data bus drive enable |
| ata_dd_in | input | 16 | Data from device |
| ata_iordy | input | 1 | Device ready (synchronous to clk) |
| irq | output | 1 | Masked interrupt |

## Verification
Each access type is run against a behavioural model that is compared on every clock. The pattern set is:
- Writes and reads at the data port and at both chip-select halves, which tell the data-port timing set from the register-access set and show which chip select is driven.
- All-zero timing words, which show that the minimum-one-clock rule applies.
- The same ready-low pattern with the handshake enabled and then disabled, which shows that the strobe stretches only when enabled.
- A changing device data bus, which shows that the read sample is taken on the last strobe clock.
- Starts issued while busy or with the DMA route bit set, and aborts issued in flight or while idle, which separate accepted commands from ignored ones.

// File: rtl/ata_pio_pkg.sv
// Shared constants and types for the PIO register transfer engine.
// Assumes a 16-bit register file addressed by word index.
package ata_pio_pkg;
    localparam int REG_W = 16;
    localparam int CNT_W = 8;

    localparam logic [3:0] IDX_CTRL  = 4'd0;
    localparam logic [3:0] IDX_DADDR = 4'd1;
    localparam logic [3:0] IDX_TXW   = 4'd2;
    localparam logic [3:0] IDX_RXW   = 4'd3;
    localparam logic [3:0] IDX_MASK  = 4'd4;
    localparam logic [3:0] IDX_STAT  = 4'd5;
    localparam logic [3:0] IDX_LEN   = 4'd6;
    localparam logic [3:0] IDX_RTIM  = 4'd7;
    localparam logic [3:0] IDX_DTIM  = 4'd8;
    localparam logic [3:0] IDX_DSTB  = 4'd9;

    localparam int CB_START = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_RDYEN = 2;
    localparam int CB_VIDMA = 3;
    localparam int CB_HALT  = 4;

    localparam int SB_DONE = 0;
    localparam int SB_TERM = 1;

    localparam logic [3:0] DATA_PORT = 4'h0;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_END    = 2'd3
    } phase_e;

    typedef struct packed {
        logic [3:0]       t_setup;
        logic [CNT_W-1:0] t_dend;
        logic [3:0]       t_hold;
        logic [CNT_W-1:0] t_dstb;
        logic [CNT_W-1:0] t_rstb;
        logic [CNT_W-1:0] t_rend;
    } pio_timing_t;

    // Zero count is stretched to one clock.
    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction
endpackage

// File: rtl/ata_pio_regs.sv
// Register file: control, address, data words, interrupt mask/status, timings.
// Decodes start and abort commands; status bits are write-one-to-clear.
// Assumes one register write per clock and combinational read-back.
module ata_pio_regs
    import ata_pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             seq_idle,
    input  logic             seq_done,
    input  logic             seq_term,
    input  logic             rx_load,
    input  logic [REG_W-1:0] rx_data,
    output logic             launch,
    output logic             launch_dir,
    output logic             launch_rdy,
    output logic             halt,
    output logic [3:0]       dev_addr,
    output logic [REG_W-1:0] tx_word,
    output pio_timing_t      timing,
    output logic             irq
);
    logic             ctl_dir, ctl_rdy, ctl_vdma;
    logic [1:0]       mask_q, stat_q, stat_clr;
    logic [REG_W-1:0] rx_q, len_q, rtim_q, dtim_q, dstb_q;
    logic             ctrl_wr;
    logic             unused_dstb_hi;

    assign ctrl_wr    = reg_we && (reg_addr == IDX_CTRL);
    assign launch     = ctrl_wr && reg_wdata[CB_START] && !reg_wdata[CB_VIDMA] && seq_idle;
    assign halt       = ctrl_wr && reg_wdata[CB_HALT] && !seq_idle;
    assign launch_dir = reg_wdata[CB_DIR];
    assign launch_rdy = reg_wdata[CB_RDYEN];
    assign stat_clr   = (reg_we && (reg_addr == IDX_STAT)) ? reg_wdata[1:0] : 2'b00;
    assign irq        = |(stat_q & mask_q);
    assign unused_dstb_hi = ^dstb_q[REG_W-1:CNT_W];

    assign timing.t_setup = dtim_q[3:0];
    assign timing.t_dend  = dtim_q[11:4];
    assign timing.t_hold  = dtim_q[15:12];
    assign timing.t_dstb  = dstb_q[CNT_W-1:0];
    assign timing.t_rstb  = rtim_q[15:8];
    assign timing.t_rend  = rtim_q[7:0];

    // Software-writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_dir  <= 1'b0;
            ctl_rdy  <= 1'b0;
            ctl_vdma <= 1'b0;
            dev_addr <= '0;
            tx_word  <= '0;
            mask_q   <= '0;
            len_q    <= '0;
            rtim_q   <= '0;
            dtim_q   <= '0;
            dstb_q   <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                IDX_CTRL: begin
                    ctl_dir  <= reg_wdata[CB_DIR];
                    ctl_rdy  <= reg_wdata[CB_RDYEN];
                    ctl_vdma <= reg_wdata[CB_VIDMA];
                end
                IDX_DADDR: dev_addr <= reg_wdata[3:0];
                IDX_TXW:   tx_word  <= reg_wdata;
                IDX_MASK:  mask_q   <= reg_wdata[1:0];
                IDX_LEN:   len_q    <= reg_wdata;
                IDX_RTIM:  rtim_q   <= reg_wdata;
                IDX_DTIM:  dtim_q   <= reg_wdata;
                IDX_DSTB:  dstb_q   <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Receive word captured by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_q <= '0;
        else if (rx_load) rx_q <= rx_data;
    end

    // Interrupt status: hardware set wins over software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | {seq_term, seq_done};
    end

    // Read-back multiplexer.
    always_comb begin
        unique case (reg_addr)
            IDX_CTRL:  reg_rdata = {12'b0, ctl_vdma, ctl_rdy, ctl_dir, 1'b0};
            IDX_DADDR: reg_rdata = {12'b0, dev_addr};
            IDX_TXW:   reg_rdata = tx_word;
            IDX_RXW:   reg_rdata = rx_q;
            IDX_MASK:  reg_rdata = {14'b0, mask_q};
            IDX_STAT:  reg_rdata = {14'b0, stat_q};
            IDX_LEN:   reg_rdata = len_q;
            IDX_RTIM:  reg_rdata = rtim_q;
            IDX_DTIM:  reg_rdata = dtim_q;
            IDX_DSTB:  reg_rdata = dstb_q;
            default:   reg_rdata = '0;
        endcase
    end

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> stat_q[SB_DONE]); // R7
    AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == IDX_STAT && reg_wdata[SB_DONE] && !seq_done) |=> !stat_q[SB_DONE]); // R7
endmodule

// File: rtl/ata_pio_seq.sv
// Phase sequencer: setup, strobe, end-of-cycle; one single-word access per launch.
// Latches address, direction, data and phase lengths at launch.
// Assumes ata_iordy is already synchronous to clk.
module ata_pio_seq
    import ata_pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             launch_dir,
    input  logic             launch_rdy,
    input  logic             halt,
    input  logic [3:0]       dev_addr,
    input  logic [REG_W-1:0] tx_word,
    input  pio_timing_t      timing,
    input  logic             ata_iordy,
    input  logic [REG_W-1:0] ata_dd_in,
    output logic             idle,
    output logic             done,
    output logic             term,
    output logic             rx_load,
    output logic [REG_W-1:0] rx_data,
    output logic [1:0]       ata_cs_n,
    output logic [2:0]       ata_da,
    output logic             ata_dior_n,
    output logic             ata_diow_n,
    output logic [REG_W-1:0] ata_dd_out,
    output logic             ata_dd_oe
);
    phase_e           ph;
    logic [CNT_W-1:0] cnt, cur_len;
    logic [CNT_W-1:0] len_setup, len_stb, len_end, len_hold;
    logic             l_dir, l_rdy;
    logic [3:0]       l_addr;
    logic [REG_W-1:0] l_tx;
    logic             last, hold, is_data;

    assign is_data = (dev_addr == DATA_PORT);
    assign hold    = (ph == PH_STROBE) && l_rdy && !ata_iordy;
    assign last    = (cnt == cur_len - CNT_W'(1));
    assign idle    = (ph == PH_IDLE);
    assign term    = halt;
    assign done    = (ph == PH_END) && last && !halt;
    assign rx_load = (ph == PH_STROBE) && last && !hold && !l_dir && !halt;
    assign rx_data = ata_dd_in;

    // Length of the phase in progress.
    always_comb begin
        unique case (ph)
            PH_SETUP:  cur_len = len_setup;
            PH_STROBE: cur_len = len_stb;
            PH_END:    cur_len = len_end;
            default:   cur_len = CNT_W'(1);
        endcase
    end

    // Capture access parameters at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_setup <= CNT_W'(1);
            len_stb   <= CNT_W'(1);
            len_end   <= CNT_W'(1);
            len_hold  <= CNT_W'(1);
            l_dir     <= 1'b0;
            l_rdy     <= 1'b0;
            l_addr    <= '0;
            l_tx      <= '0;
        end else if (launch) begin
            len_setup <= at_least_one(CNT_W'(timing.t_setup));
            len_hold  <= at_least_one(CNT_W'(timing.t_hold));
            len_stb   <= at_least_one(is_data ? timing.t_dstb : timing.t_rstb);
            len_end   <= at_least_one(is_data ? timing.t_dend : timing.t_rend);
            l_dir     <= launch_dir;
            l_rdy     <= launch_rdy;
            l_addr    <= dev_addr;
            l_tx      <= tx_word;
        end
    end

    // Phase and in-phase counter; abort returns to idle at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else if (halt) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (launch) begin
                    ph  <= PH_SETUP;
                    cnt <= '0;
                end
                PH_SETUP: if (last) begin
                    ph  <= PH_STROBE;
                    cnt <= '0;
                end else cnt <= cnt + CNT_W'(1);
                PH_STROBE: if (!hold) begin
                    if (last) begin
                        ph  <= PH_END;
                        cnt <= '0;
                    end else cnt <= cnt + CNT_W'(1);
                end
                PH_END: if (last) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end else cnt <= cnt + CNT_W'(1);
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Device-side outputs decoded from the registered phase.
    always_comb begin
        ata_cs_n   = idle ? 2'b11 : (l_addr[3] ? 2'b01 : 2'b10);
        ata_da     = idle ? 3'b000 : l_addr[2:0];
        ata_dior_n = !((ph == PH_STROBE) && !l_dir);
        ata_diow_n = !((ph == PH_STROBE) && l_dir);
        ata_dd_oe  = l_dir && ((ph == PH_SETUP) || (ph == PH_STROBE) ||
                               ((ph == PH_END) && (cnt < len_hold)));
        ata_dd_out = idle ? '0 : l_tx;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_dior_n && !ata_diow_n)); // R3
    AST_CS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_dior_n || !ata_diow_n) |-> (ata_cs_n != 2'b11)); // R2
    AST_IORDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_STROBE && l_rdy && !ata_iordy && !halt) |=> (ph == PH_STROBE && $stable(cnt))); // R6
    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (ata_cs_n == 2'b11 && ata_dior_n && ata_diow_n)); // R11
    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (ph == PH_IDLE)); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ph == PH_IDLE && !ata_dd_oe)); // R7
endmodule

// File: rtl/ata_pio_engine.sv
// Top of the PIO register transfer engine: register file plus phase sequencer.
// Assumes synchronous active-low reset and a ready input already in the clk domain.
module ata_pio_engine
    import ata_pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [1:0]       ata_cs_n,
    output logic [2:0]       ata_da,
    output logic             ata_dior_n,
    output logic             ata_diow_n,
    output logic [REG_W-1:0] ata_dd_out,
    output logic             ata_dd_oe,
    input  logic [REG_W-1:0] ata_dd_in,
    input  logic             ata_iordy,
    output logic             irq
);
    logic             seq_idle, seq_done, seq_term, rx_load;
    logic [REG_W-1:0] rx_data, tx_word;
    logic             launch, launch_dir, launch_rdy, halt;
    logic [3:0]       dev_addr;
    pio_timing_t      timing;

    ata_pio_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .seq_idle   (seq_idle),
        .seq_done   (seq_done),
        .seq_term   (seq_term),
        .rx_load    (rx_load),
        .rx_data    (rx_data),
        .launch     (launch),
        .launch_dir (launch_dir),
        .launch_rdy (launch_rdy),
        .halt       (halt),
        .dev_addr   (dev_addr),
        .tx_word    (tx_word),
        .timing     (timing),
        .irq        (irq)
    );

    ata_pio_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_dir (launch_dir),
        .launch_rdy (launch_rdy),
        .halt       (halt),
        .dev_addr   (dev_addr),
        .tx_word    (tx_word),
        .timing     (timing),
        .ata_iordy  (ata_iordy),
        .ata_dd_in  (ata_dd_in),
        .idle       (seq_idle),
        .done       (seq_done),
        .term       (seq_term),
        .rx_load    (rx_load),
        .rx_data    (rx_data),
        .ata_cs_n   (ata_cs_n),
        .ata_da     (ata_da),
        .ata_dior_n (ata_dior_n),
        .ata_diow_n (ata_diow_n),
        .ata_dd_out (ata_dd_out),
        .ata_dd_oe  (ata_dd_oe)
    );
endmodule

// File: tb/ata_pio_engine_tb_top.sv
// Bench: behavioural per-clock model plus directed length/readback checks.
module ata_pio_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [1:0]  ata_cs_n;
    logic [2:0]  ata_da;
    logic        ata_dior_n, ata_diow_n, ata_dd_oe, irq;
    logic [15:0] ata_dd_out;
    logic [15:0] ata_dd_in = 16'h1000;
    logic        ata_iordy = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    ata_pio_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ata_cs_n(ata_cs_n),
        .ata_da(ata_da), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
        .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in),
        .ata_iordy(ata_iordy), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) ata_dd_in <= ata_dd_in + 16'h0111;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_ph, m_cnt, m_ls, m_lw, m_le, m_lh;
    logic        m_ldir, m_lrdy;
    logic [3:0]  m_laddr;
    logic [15:0] m_ltx;
    logic        m_dir, m_rdy, m_dma;
    logic [3:0]  m_addr;
    logic [15:0] m_tx, m_rx, m_len, m_rt, m_dt, m_ds;
    logic [1:0]  m_mask, m_stat;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return {12'b0, m_dma, m_rdy, m_dir, 1'b0};
            4'd1: return {12'b0, m_addr};
            4'd2: return m_tx;
            4'd3: return m_rx;
            4'd4: return {14'b0, m_mask};
            4'd5: return {14'b0, m_stat};
            4'd6: return m_len;
            4'd7: return m_rt;
            4'd8: return m_dt;
            4'd9: return m_ds;
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit cw, go, hlt, hld, lst, dn;
        int cl;
        logic [1:0] clr;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_ls = 1; m_lw = 1; m_le = 1; m_lh = 1;
            m_ldir = 0; m_lrdy = 0; m_laddr = 0; m_ltx = 0;
            m_dir = 0; m_rdy = 0; m_dma = 0; m_addr = 0; m_tx = 0; m_rx = 0;
            m_len = 0; m_rt = 0; m_dt = 0; m_ds = 0; m_mask = 0; m_stat = 0;
        end else begin
            cw  = reg_we && (reg_addr == 4'd0);
            go  = cw && reg_wdata[0] && !reg_wdata[3] && (m_ph == 0);
            hlt = cw && reg_wdata[4] && (m_ph != 0);
            hld = (m_ph == 2) && m_lrdy && !ata_iordy;
            cl  = (m_ph == 1) ? m_ls : (m_ph == 2) ? m_lw : (m_ph == 3) ? m_le : 1;
            lst = (m_cnt == cl - 1);
            dn  = (m_ph == 3) && lst && !hlt;
            if ((m_ph == 2) && lst && !hld && !m_ldir && !hlt) m_rx = ata_dd_in;
            clr = (reg_we && reg_addr == 4'd5) ? reg_wdata[1:0] : 2'b00;
            m_stat = (m_stat & ~clr) | {hlt, dn};
            if (hlt) begin
                m_ph = 0; m_cnt = 0;
            end else begin
                case (m_ph)
                    0: if (go) begin
                        m_ph = 1; m_cnt = 0;
                        m_ls = eff(int'(m_dt[3:0]));
                        m_lh = eff(int'(m_dt[15:12]));
                        m_lw = (m_addr == 0) ? eff(int'(m_ds[7:0])) : eff(int'(m_rt[15:8]));
                        m_le = (m_addr == 0) ? eff(int'(m_dt[11:4])) : eff(int'(m_rt[7:0]));
                        m_ldir = reg_wdata[1]; m_lrdy = reg_wdata[2];
                        m_laddr = m_addr; m_ltx = m_tx;
                    end
                    1: if (lst) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
                    2: if (!hld) begin
                        if (lst) begin m_ph = 3; m_cnt = 0; end else m_cnt++;
                    end
                    default: if (lst) begin m_ph = 0; m_cnt = 0; end else m_cnt++;
                endcase
            end
            if (reg_we) begin
                case (reg_addr)
                    4'd0: begin m_dir = reg_wdata[1]; m_rdy = reg_wdata[2]; m_dma = reg_wdata[3]; end
                    4'd1: m_addr = reg_wdata[3:0];
                    4'd2: m_tx = reg_wdata;
                    4'd4: m_mask = reg_wdata[1:0];
                    4'd6: m_len = reg_wdata;
                    4'd7: m_rt = reg_wdata;
                    4'd8: m_dt = reg_wdata;
                    4'd9: m_ds = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison, a quarter period after the edge.
    always begin : compare
        logic [1:0] ecs;
        logic eoe;
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (!finished) begin
            ecs = (m_ph == 0) ? 2'b11 : (m_laddr[3] ? 2'b01 : 2'b10);
            eoe = m_ldir && ((m_ph == 1) || (m_ph == 2) || ((m_ph == 3) && (m_cnt < m_lh)));
            chk("R2 cs_n", {14'b0, ata_cs_n}, {14'b0, ecs});
            chk("R2 da", {13'b0, ata_da}, {13'b0, (m_ph == 0) ? 3'b000 : m_laddr[2:0]});
            chk("R4 dior_n", {15'b0, ata_dior_n}, {15'b0, !((m_ph == 2) && !m_ldir)});
            chk("R3 diow_n", {15'b0, ata_diow_n}, {15'b0, !((m_ph == 2) && m_ldir)});
            chk("R3 dd_oe", {15'b0, ata_dd_oe}, {15'b0, eoe});
            if (eoe) chk("R3 dd_out", ata_dd_out, m_ltx);
            chk("R8 irq", {15'b0, irq}, {15'b0, |(m_stat & m_mask)});
            chk("R1 rdata", reg_rdata, m_read(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic measure(output int busy, output int stb, output int oe,
                           output logic [1:0] fcs, output logic [2:0] fda);
        busy = 0; stb = 0; oe = 0;
        fcs = ata_cs_n; fda = ata_da;
        while (ata_cs_n !== 2'b11 && busy < 1000) begin
            busy++;
            if (!ata_dior_n || !ata_diow_n) stb++;
            if (ata_dd_oe) oe++;
            @(negedge clk);
        end
    endtask

    task automatic idle_for(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, {14'b0, ata_cs_n}, 16'h0003);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int b, s, o;
        logic [1:0] fc;
        logic [2:0] fd;
        logic [15:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cs_n", {14'b0, ata_cs_n}, 16'h0003);
        chk("R1 strobes", {14'b0, ata_dior_n, ata_diow_n}, 16'h0003);
        chk("R1 oe", {15'b0, ata_dd_oe}, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0000);
        rd(4'd8, v); chk("R1 dtim", v, 16'h0000);
        rd(4'd5, v); chk("R1 stat", v, 16'h0000);

        // timing: t1=2 t2=3 t4=1; data strobe 4; register strobe 5 end 2
        wr(4'd8, 16'h1032);
        wr(4'd9, 16'h0004);
        wr(4'd7, 16'h0502);
        wr(4'd6, 16'h0001);

        // data-port write
        wr(4'd1, 16'h0000);
        wr(4'd2, 16'hBEEF);
        wr(4'd0, 16'h0003);
        measure(b, s, o, fc, fd);
        chk("R5 data write busy", 16'(b), 16'd9);
        chk("R3 write strobe clocks", 16'(s), 16'd4);
        chk("R3 write drive clocks", 16'(o), 16'd7);
        chk("R2 data port cs", {14'b0, fc}, 16'h0002);
        rd(4'd5, v); chk("R7 done set", v, 16'h0001);
        chk("R8 masked off", {15'b0, irq}, 16'h0000);

        // taskfile read, low chip select half
        wr(4'd1, 16'h0007);
        wr(4'd0, 16'h0001);
        measure(b, s, o, fc, fd);
        chk("R5 reg read busy", 16'(b), 16'd9);
        chk("R4 read strobe clocks", 16'(s), 16'd5);
        chk("R4 read no drive", 16'(o), 16'd0);
        chk("R2 cs low half", {14'b0, fc}, 16'h0002);
        chk("R2 da", {13'b0, fd}, 16'h0007);
        rd(4'd3, v); chk("R4 rx word", v, m_rx);

        // taskfile read, high chip select half
        wr(4'd1, 16'h000E);
        wr(4'd0, 16'h0001);
        measure(b, s, o, fc, fd);
        chk("R2 cs high half", {14'b0, fc}, 16'h0001);
        chk("R2 da high", {13'b0, fd}, 16'h0006);
        rd(4'd3, v); chk("R4 rx word 2", v, m_rx);

        // zero timings stretch to one clock
        wr(4'd8, 16'h0000);
        wr(4'd9, 16'h0000);
        wr(4'd7, 16'h0000);
        wr(4'd1, 16'h0000);
        wr(4'd0, 16'h0003);
        measure(b, s, o, fc, fd);
        chk("R5 zero data busy", 16'(b), 16'd3);
        chk("R5 zero strobe", 16'(s), 16'd1);
        chk("R3 zero drive", 16'(o), 16'd3);
        wr(4'd1, 16'h0003);
        wr(4'd0, 16'h0001);
        measure(b, s, o, fc, fd);
        chk("R5 zero reg busy", 16'(b), 16'd3);

        // ready handshake enabled then disabled
        wr(4'd8, 16'h1032);
        wr(4'd9, 16'h0004);
        wr(4'd7, 16'h0502);
        wr(4'd1, 16'h0000);
        ata_iordy = 1'b0;
        wr(4'd0, 16'h0005);
        fork
            measure(b, s, o, fc, fd);
            begin repeat (5) @(negedge clk); ata_iordy = 1'b1; end
        join
        chk("R6 stretched strobe", 16'(s), 16'd7);
        chk("R6 stretched busy", 16'(b), 16'd12);
        rd(4'd3, v); chk("R6 rx after wait", v, m_rx);
        ata_iordy = 1'b0;
        wr(4'd0, 16'h0001);
        fork
            measure(b, s, o, fc, fd);
            begin repeat (5) @(negedge clk); ata_iordy = 1'b1; end
        join
        chk("R6 ignored strobe", 16'(s), 16'd4);
        chk("R6 ignored busy", 16'(b), 16'd9);

        // status and interrupt mask
        chk("R8 irq masked", {15'b0, irq}, 16'h0000);
        wr(4'd4, 16'h0001);
        chk("R8 irq on", {15'b0, irq}, 16'h0001);
        wr(4'd5, 16'h0000);
        rd(4'd5, v); chk("R7 write zero keeps", v, 16'h0001);
        wr(4'd5, 16'h0001);
        rd(4'd5, v); chk("R7 write one clears", v, 16'h0000);
        chk("R8 irq off", {15'b0, irq}, 16'h0000);

        // start while busy is ignored
        wr(4'd1, 16'h0007);
        wr(4'd0, 16'h0003);
        fork
            measure(b, s, o, fc, fd);
            wr(4'd0, 16'h0003);
        join
        chk("R9 single access busy", 16'(b), 16'd9);
        chk("R9 single strobe", 16'(s), 16'd5);
        idle_for(4, "R9 no second access");
        rd(4'd0, v); chk("R9 start self clears", v, 16'h0002);

        // DMA route bit blocks start
        wr(4'd5, 16'h0003);
        wr(4'd0, 16'h000B);
        chk("R10 no cycle", {14'b0, ata_cs_n}, 16'h0003);
        idle_for(4, "R10 stays idle");
        rd(4'd5, v); chk("R10 no status", v, 16'h0000);
        rd(4'd0, v); chk("R10 ctrl readback", v, 16'h000A);
        wr(4'd0, 16'h0000);

        // abort in flight and while idle
        wr(4'd4, 16'h0002);
        wr(4'd0, 16'h0001);
        repeat (2) @(negedge clk);
        chk("R11 busy before abort", {15'b0, ata_cs_n == 2'b11}, 16'h0000);
        wr(4'd0, 16'h0010);
        chk("R11 bus idle", {14'b0, ata_cs_n}, 16'h0003);
        rd(4'd5, v); chk("R11 term flag", v, 16'h0002);
        chk("R11 irq", {15'b0, irq}, 16'h0001);
        idle_for(3, "R11 stays idle");
        wr(4'd5, 16'h0003);
        wr(4'd0, 16'h0010);
        rd(4'd5, v); chk("R11 idle abort no effect", v, 16'h0000);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule